// File: doc/BRIEF.md
# Multi-Lane Expected-Word Match Latch

This block sits at the end of a multi-lane link test path. Every clock cycle it receives one 8-bit word per lane, already realigned to byte boundaries, together with the single expected word that a local pattern generator produces for that cycle. All lanes carry the same test pattern, so one expected word serves every lane. Each lane's word is compared with the expected word. The equality results of all lanes are combined with a logical AND, and that result is stored in a one-bit register. The register output drives a pass indicator such as an LED.

Comparison is qualified by the data-valid signal from the alignment logic. The same signal starts the external expected-word generator. The match register is only loaded with a comparison result in a cycle where valid is high. In every other cycle it loads 0, so an idle or misaligned link never shows a pass. The register reloads every cycle. A single corrupt word on any lane therefore drops the indicator for exactly one cycle, and the indicator comes back as soon as the data agree again.

The input is a stream with valid but no ready: the block examines every word the moment it arrives and never applies back-pressure, so the upstream side never has to stall. Optionally, a parameter brings out the registered equality bit of each lane, with the same timing as the combined bit, for lane-level diagnosis.

Top module: `lane_match_latch`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and in the first cycle after it is released, `match_o` is 0 and every bit of `lane_match_o` is 0.
- R2: When `in_valid` is 1 at a rising clock edge and every lane word equals `exp_word`, `match_o` is 1 after that edge.
- R3: When `in_valid` is 1 at a rising clock edge and at least one lane word differs from `exp_word`, `match_o` is 0 after that edge. If the next valid cycle has all lanes equal, `match_o` returns to 1 after that edge.
- R4: When `in_valid` is 0 at a rising clock edge, `match_o` is 0 after that edge, whatever the lane words and the expected word are.
- R5: With `EXPOSE_LANES`=1 (the default), bit i of `lane_match_o` after a rising edge is 1 exactly when `in_valid` was 1 at that edge and lane i matched `exp_word`. When `in_valid` was 0, all bits are 0.
- R6: Lane i occupies bits [8i+7:8i] of `in_lanes`, so lane 0 is the least significant byte. A mismatch placed in any single lane, including the first and the last, is detected on its own.
- R7: The lane count is the parameter `LANES`, default 15. The result is the AND over all lanes, so every lane takes part in the pass indicator.
- R8: No back-pressure: a new lane-word set is taken every cycle, and consecutive valid cycles with different words are each judged on their own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Aligned data valid; qualifies the current words |
| in_lanes | input | LANES*WORD_W | Aligned lane words, lane i at bits [WORD_W*i+WORD_W-1:WORD_W*i] |
| exp_word | input | WORD_W | Expected word shared by all lanes |
| match_o | output | 1 | Registered AND of all lane equalities; drives the pass indicator |
| lane_match_o | output | LANES | Registered per-lane equality bits (all 0 when not exposed) |

## Verification
The register holds only one bit of state, and it is rewritten every cycle, so a wrong value is visible on `match_o` exactly one clock after the input word set that caused it. It does not persist beyond the next valid cycle. A faulty lane comparator or a missing term in the AND tree shows up only when the mismatch is placed in that particular lane. For that reason, errors are injected in the first, a middle and the last lane. The exposed per-lane bits tell a broken comparator apart from a broken combining stage in the same cycle.

// File: rtl/lml_pkg.sv
package lml_pkg;
  localparam int DEF_LANES  = 15;
  localparam int DEF_WORD_W = 8;

  function automatic int tree_levels(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction
endpackage

// File: rtl/lml_lane_cmp.sv
module lml_lane_cmp #(
  parameter int WORD_W = lml_pkg::DEF_WORD_W
) (
  input  logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] exp_word,
  output logic              eq
);
  always_comb eq = (rx_word == exp_word);
endmodule

// File: rtl/lml_and_tree.sv
module lml_and_tree #(
  parameter int N = lml_pkg::DEF_LANES
) (
  input  logic [N-1:0] bits_in,
  output logic         all_set
);
  localparam int LEVELS = lml_pkg::tree_levels(N);
  localparam int PADDED = 1 << LEVELS;

  logic [PADDED-1:0] node [LEVELS+1];

  // Leaves: real inputs, padding forced high so it never masks a result
  for (genvar i = 0; i < PADDED; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign node[0][i] = bits_in[i];
    end else begin : g_pad
      assign node[0][i] = 1'b1;
    end
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int WIDTH = PADDED >> (l + 1);
    for (genvar j = 0; j < PADDED; j++) begin : g_node
      if (j < WIDTH) begin : g_and
        assign node[l+1][j] = node[l][2*j] & node[l][2*j+1];
      end else begin : g_unused
        assign node[l+1][j] = 1'b1;
      end
    end
  end

  assign all_set = node[LEVELS][0];
endmodule

// File: rtl/lml_match_reg.sv
module lml_match_reg #(
  parameter int LANES        = lml_pkg::DEF_LANES,
  parameter bit EXPOSE_LANES = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             all_eq,
  input  logic [LANES-1:0] lane_eq,
  output logic             match_q,
  output logic [LANES-1:0] lane_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= valid & all_eq;
  end

  if (EXPOSE_LANES) begin : g_expose
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= valid ? lane_eq : '0;
    end
  end else begin : g_hide
    assign lane_q = '0;
  end
endmodule

// File: rtl/lane_match_latch.sv
module lane_match_latch #(
  parameter int LANES        = lml_pkg::DEF_LANES,
  parameter int WORD_W       = lml_pkg::DEF_WORD_W,
  parameter bit EXPOSE_LANES = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*WORD_W-1:0] in_lanes,
  input  logic [WORD_W-1:0]       exp_word,
  output logic                    match_o,
  output logic [LANES-1:0]        lane_match_o
);
  logic [LANES-1:0] lane_eq;
  logic             all_eq;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lml_lane_cmp #(.WORD_W(WORD_W)) u_cmp (
      .rx_word (in_lanes[i*WORD_W +: WORD_W]),
      .exp_word(exp_word),
      .eq      (lane_eq[i])
    );
  end

  lml_and_tree #(.N(LANES)) u_tree (
    .bits_in(lane_eq),
    .all_set(all_eq)
  );

  lml_match_reg #(.LANES(LANES), .EXPOSE_LANES(EXPOSE_LANES)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (in_valid),
    .all_eq (all_eq),
    .lane_eq(lane_eq),
    .match_q(match_o),
    .lane_q (lane_match_o)
  );
endmodule

// File: rtl/lml_checker.sv
module lml_checker #(
  parameter int LANES        = lml_pkg::DEF_LANES,
  parameter int WORD_W       = lml_pkg::DEF_WORD_W,
  parameter bit EXPOSE_LANES = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [LANES*WORD_W-1:0] in_lanes,
  input logic [WORD_W-1:0]       exp_word,
  input logic                    match_o,
  input logic [LANES-1:0]        lane_match_o
);
  logic             was_rst = 1'b0;
  logic [LANES-1:0] ref_eq;

  always_comb begin
    for (int i = 0; i < LANES; i++)
      ref_eq[i] = (in_lanes[i*WORD_W +: WORD_W] == exp_word);
  end

  always_ff @(posedge clk) was_rst <= !rst_n;

  // R1: first sample after reset release still shows cleared outputs
  always_ff @(posedge clk) begin
    if (rst_n && was_rst)
      assert_reset_clear_R1: assert (!match_o && lane_match_o == '0);
  end

  assert_all_equal_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&ref_eq)) |=> match_o);

  assert_any_mismatch_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(&ref_eq)) |=> !match_o);

  assert_invalid_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!match_o && lane_match_o == '0));

  if (EXPOSE_LANES) begin : g_lane_chk
    assert_pass_implies_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> (&lane_match_o));
    assert_lane_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (lane_match_o == $past(ref_eq)));
  end
endmodule

bind lane_match_latch lml_checker #(
  .LANES(LANES), .WORD_W(WORD_W), .EXPOSE_LANES(EXPOSE_LANES)
) u_lml_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lanes(in_lanes),
  .exp_word(exp_word), .match_o(match_o), .lane_match_o(lane_match_o)
);

// File: tb/test_lane_match_latch.sv
module test_lane_match_latch;
  localparam int LANES = 15;
  localparam int W     = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [LANES*W-1:0] in_lanes = '0;
  logic [W-1:0]       exp_word = '0;
  logic               match_o;
  logic [LANES-1:0]   lane_match_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_match_latch i_lane_match_latch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lanes(in_lanes),
    .exp_word(exp_word), .match_o(match_o), .lane_match_o(lane_match_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one word set at the falling edge, then sample one falling edge later
  task automatic step(input logic v, input logic [W-1:0] e, input int bad_mask_lane,
                      input logic [W-1:0] flip);
    @(negedge clk);
    in_valid = v;
    exp_word = e;
    for (int i = 0; i < LANES; i++)
      in_lanes[i*W +: W] = (i == bad_mask_lane) ? (e ^ flip) : e;
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] pat(input int k);
    return W'(k * 37 + 11);
  endfunction

  function automatic logic [LANES-1:0] lanes_ok(input int bad);
    logic [LANES-1:0] m = '1;
    if (bad >= 0 && bad < LANES) m[bad] = 1'b0;
    return m;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 match in reset", 32'(match_o), 0);
    chk("R1 lanes in reset", 32'(lane_match_o), 0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 match after release", 32'(match_o), 0);
  endtask

  task automatic t_all_match();
    for (int k = 0; k < 6; k++) begin
      step(1'b1, pat(k), -1, 8'h00);
      chk("R2 all lanes equal", 32'(match_o), 1);
      chk("R8 back-to-back words", 32'(lane_match_o), 32'(lanes_ok(-1)));
    end
  endtask

  task automatic t_single_error();
    int lanes_to_hit [3] = '{0, 7, LANES-1};
    foreach (lanes_to_hit[n]) begin
      step(1'b1, pat(20 + n), lanes_to_hit[n], 8'h10);
      chk("R6 single lane mismatch", 32'(match_o), 0);
      chk("R5 lane bit cleared", 32'(lane_match_o), 32'(lanes_ok(lanes_to_hit[n])));
      step(1'b1, pat(30 + n), -1, 8'h00);
      chk("R3 recovery next cycle", 32'(match_o), 1);
    end
    step(1'b1, 8'h00, 3, 8'h80);
    chk("R3 msb flip detected", 32'(match_o), 0);
  endtask

  task automatic t_valid_low();
    step(1'b0, pat(40), -1, 8'h00);
    chk("R4 equal data but invalid", 32'(match_o), 0);
    chk("R5 lanes zero when invalid", 32'(lane_match_o), 0);
    step(1'b0, pat(41), 5, 8'h01);
    chk("R4 mismatch and invalid", 32'(match_o), 0);
    step(1'b1, pat(42), -1, 8'h00);
    chk("R4 valid again passes", 32'(match_o), 1);
  endtask

  task automatic t_all_lanes_bad();
    @(negedge clk);
    in_valid = 1'b1;
    exp_word = 8'hA5;
    for (int i = 0; i < LANES; i++) in_lanes[i*W +: W] = 8'h5A;
    @(negedge clk);
    chk("R7 every lane wrong", 32'(match_o), 0);
    chk("R5 all lane bits low", 32'(lane_match_o), 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_all_match();
    t_single_error();
    t_valid_low();
    t_all_lanes_bad();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule